// File: doc/BRIEF.md
# Resolver Angle Tracking Loop

This block turns demodulated resolver samples into a 14-bit shaft angle. On every cycle where `sample_valid_i` is high it takes one signed sine sample and one signed cosine sample of the shaft angle θ. It multiplies them by the cosine and sine of the angle φ held in its own counter, and subtracts the two products. The result is proportional to sin(θ − φ).

That error passes through a compensator with one pole and one zero, and then into a velocity integrator. The sum drives a numerically controlled oscillator. Each carry out of the oscillator moves the angle counter by exactly one LSB, up or down. The loop has two integrators: the velocity register and the counter itself. A constant shaft speed is therefore followed with no steady lag, and only acceleration leaves a residual error.

The sine and cosine of φ come from a quarter-wave table with quadrant folding and first-order interpolation between entries. The signed error is exported in LSB units so that a downstream fault monitor can compare it against its thresholds. Carrier demodulation and analog front ends sit outside this block.

Top module: `trk_angle_loop`

## Requirements
- R1: While `rst_ni` is low, `angle_o` is 0, `err_o` is 0, and `step_up_o` and `step_dn_o` are both 0.
- R2: A change of `angle_o` is always exactly one LSB, and it appears in the same cycle as a one-cycle pulse on `step_up_o` (for +1) or on `step_dn_o` (for −1). The two strobes are never high together, and neither is high in a cycle where the angle did not move.
- R3: The loop advances only on cycles with `sample_valid_i` high. After a cycle with it low, `angle_o` and `err_o` keep their values and neither strobe is set, whatever the sample inputs are.
- R4: The counter wraps modulo 16384. A step up from 16383 gives 0, a step down from 0 gives 16383, and the loop tracks across the wrap by the short path.
- R5: For a constant input angle in any quadrant, `angle_o` settles to within ±1 LSB of the input angle.
- R6: `err_o` is the signed value of sinθ·cosφ − cosθ·sinφ, scaled so that one count equals one angle LSB when the sample amplitude is 16384. It is positive when the input leads the counter and is updated on each valid sample. It reads within ±1 of the true offset for small offsets, and within ±1 at lock.
- R7: For an input rotating at a constant rate (0.25 and 0.75 LSB per sample were tried), once the loop has settled the counter stays within ±2 LSB of the input and `|err_o| ≤ 2`, so there is no velocity lag.
- R8: At most one step occurs per valid sample. The velocity integrator and the oscillator input saturate, so a large error makes the counter slew at close to one step per sample, continuously, in the direction that reduces the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Marks a cycle carrying a new sine/cosine sample pair |
| sin_i | input | 16 | Signed sine sample of the shaft angle |
| cos_i | input | 16 | Signed cosine sample of the shaft angle |
| angle_o | output | 14 | Tracked angle, natural binary, 1 LSB = 360/16384 degrees |
| step_up_o | output | 1 | One-cycle pulse, counter moved +1 |
| step_dn_o | output | 1 | One-cycle pulse, counter moved −1 |
| err_o | output | 16 | Signed tracking error in angle LSBs |

## Verification
The properties check, on every cycle, that the counter moves one LSB at a time, that each move matches its direction strobe, and that nothing moves without a valid sample. They also check that the oscillator's carry direction agrees with the sign of its rate input.

Only the bench scenarios can show whether the interpolated table and the error scaling are numerically right. That covers locking in all four quadrants, the short-path wrap, zero lag on constant-speed ramps, and the full-rate slew after a large step. Those results depend on the loop settling over thousands of samples, not on any single-cycle relation.

// File: rtl/trk_pkg.sv
package trk_pkg;

  localparam real PI = 3.14159265358979323846;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Rounded amp*sin(k/steps * 90deg), used to fill the quarter-wave table.
  function automatic int sin_tab(input int k, input int steps, input int amp);
    return $rtoi(real'(amp) * $sin(PI / 2.0 * real'(k) / real'(steps)) + 0.5);
  endfunction

endpackage

// File: rtl/trk_sincos.sv
module trk_sincos
  import trk_pkg::*;
#(
  parameter int ANG_W  = 14,
  parameter int TRIG_W = 16,
  parameter int LUT_AW = 8
) (
  input  logic        [ANG_W-1:0]  ang_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);

  localparam int QW  = ANG_W - 2;          // position inside a quadrant
  localparam int FW  = QW - LUT_AW;        // interpolation bits
  localparam int TN  = (1 << LUT_AW) + 1;  // includes the 90 degree point
  localparam int AMP = (1 << (TRIG_W - 1)) - 1;
  localparam int KB  = 20;
  localparam int KI  = $rtoi(2.0 * PI * (2.0 ** KB) / (2.0 ** ANG_W) + 0.5);
  localparam int CW  = TRIG_W + FW + KB;
  localparam int SW  = TRIG_W + 2;

  logic signed [TRIG_W-1:0] tbl [TN];

  for (genvar k = 0; k < TN; k++) begin : g_tbl
    assign tbl[k] = TRIG_W'(sin_tab(k, TN - 1, AMP));
  end

  // x[0] = r, x[1] = quarter - r, so fs[0] = sin(r) and fs[1] = cos(r)
  logic [QW:0]              x  [2];
  logic signed [TRIG_W-1:0] fs [2];

  assign x[0] = {1'b0, ang_i[QW-1:0]};
  assign x[1] = (QW+1)'(1 << QW) - x[0];

  for (genvar j = 0; j < 2; j++) begin : g_fine
    logic        [LUT_AW:0] ci;
    logic        [LUT_AW:0] cc;
    logic signed [CW-1:0]   corr;
    logic signed [SW-1:0]   sum;

    assign ci   = x[j][QW:FW];
    assign cc   = (LUT_AW+1)'(TN - 1) - ci;
    // sin(a + d) ~ sin(a) + d * cos(a)
    assign corr = (CW'(tbl[cc]) * CW'($signed({1'b0, x[j][FW-1:0]})) * CW'(KI)) >>> KB;
    assign sum  = SW'(tbl[ci]) + SW'(corr);
    assign fs[j] = (sum > SW'(AMP)) ? TRIG_W'(AMP) : TRIG_W'(sum);
  end

  always_comb begin
    unique case (ang_i[ANG_W-1 -: 2])
      2'd0: begin sin_o =  fs[0]; cos_o =  fs[1]; end
      2'd1: begin sin_o =  fs[1]; cos_o = -fs[0]; end
      2'd2: begin sin_o = -fs[0]; cos_o = -fs[1]; end
      default: begin sin_o = -fs[1]; cos_o =  fs[0]; end
    endcase
  end

endmodule

// File: rtl/trk_phase_det.sv
module trk_phase_det
  import trk_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int TRIG_W   = 16,
  parameter int ANG_W    = 14,
  parameter int EF_W     = 20,
  parameter int ERR_FRAC = 4,
  parameter int NOM_AMP  = 16384
) (
  input  logic signed [SMP_W-1:0]  sin_i,
  input  logic signed [SMP_W-1:0]  cos_i,
  input  logic signed [TRIG_W-1:0] sin_phi_i,
  input  logic signed [TRIG_W-1:0] cos_phi_i,
  output logic signed [EF_W-1:0]   err_f_o
);

  localparam int PM   = SMP_W + TRIG_W;
  localparam int PW   = PM + 1;
  localparam int TAMP = (1 << (TRIG_W - 1)) - 1;
  localparam int KS   = 32;
  // counts per LSB at nominal amplitude: NOM_AMP * TAMP * 2pi / 2^ANG_W
  localparam int KE   = $rtoi((2.0 ** KS) * (2.0 ** ANG_W) /
                              (real'(NOM_AMP) * real'(TAMP) * 2.0 * PI) + 0.5);
  localparam logic signed [63:0] EMAX = (64'sd1 <<< (EF_W - 1)) - 64'sd1;

  logic signed [PM-1:0] p0, p1;
  logic signed [PW-1:0] d;
  logic signed [63:0]   d64, sc;

  assign p0  = PM'(sin_i) * PM'(cos_phi_i);
  assign p1  = PM'(cos_i) * PM'(sin_phi_i);
  assign d   = PW'(p0) - PW'(p1);
  assign d64 = 64'(d);
  assign sc  = (d64 * 64'(KE)) >>> (KS - ERR_FRAC);

  always_comb begin
    if (sc > EMAX)        err_f_o = EF_W'(EMAX);
    else if (sc < -EMAX)  err_f_o = EF_W'(-EMAX);
    else                  err_f_o = EF_W'(sc);
  end

endmodule

// File: rtl/trk_loop_filter.sv
module trk_loop_filter
  import trk_pkg::*;
#(
  parameter int EF_W    = 20,
  parameter int NCO_F   = 16,
  parameter int LP_SH   = 3,
  parameter int KP_GAIN = 192,
  parameter int KI_SH   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [EF_W-1:0] err_f_i,
  output step_e                  step_o
);

  localparam int YW   = EF_W + LP_SH + 1;
  localparam int VW   = NCO_F + 2;
  localparam int RW   = EF_W + NCO_F + 12;
  localparam int RMAX = (1 << NCO_F) - 1;

  logic signed [YW-1:0]   y_acc;
  logic signed [VW-1:0]   v_q;
  logic        [NCO_F-1:0] acc_q;
  logic signed [EF_W-1:0] y_f;
  logic signed [RW-1:0]   v_sum, rate_raw, rate, nco_sum;

  function automatic logic signed [RW-1:0] clamp_rate(input logic signed [RW-1:0] x);
    if (x > RW'(RMAX))       return RW'(RMAX);
    else if (x < -RW'(RMAX)) return -RW'(RMAX);
    else                     return x;
  endfunction

  // pole: first-order low-pass on the error
  assign y_f      = EF_W'(y_acc >>> LP_SH);
  // zero: proportional path beside the velocity integrator
  assign v_sum    = RW'(v_q) + (RW'(y_f) <<< KI_SH);
  assign rate_raw = RW'(v_q) + RW'(y_f) * RW'(KP_GAIN);
  assign rate     = clamp_rate(rate_raw);
  assign nco_sum  = RW'($signed({1'b0, acc_q})) + rate;

  always_comb begin
    if (!valid_i)                        step_o = STEP_HOLD;
    else if (nco_sum >= RW'(1 << NCO_F)) step_o = STEP_UP;
    else if (nco_sum < 0)                step_o = STEP_DN;
    else                                 step_o = STEP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_acc <= '0;
      v_q   <= '0;
      acc_q <= '0;
    end else if (valid_i) begin
      y_acc <= y_acc + YW'(err_f_i) - (y_acc >>> LP_SH);
      v_q   <= VW'(clamp_rate(v_sum));
      acc_q <= nco_sum[NCO_F-1:0];
    end
  end

  // R8
  step_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == STEP_UP) |-> (rate > 0));

  // R8
  step_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == STEP_DN) |-> (rate < 0));

endmodule

// File: rtl/trk_angle_loop.sv
module trk_angle_loop
  import trk_pkg::*;
#(
  parameter int ANG_W    = 14,
  parameter int SMP_W    = 16,
  parameter int TRIG_W   = 16,
  parameter int LUT_AW   = 8,
  parameter int ERR_W    = 16,
  parameter int ERR_FRAC = 4,
  parameter int NCO_F    = 16,
  parameter int NOM_AMP  = 16384
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_valid_i,
  input  logic signed [SMP_W-1:0] sin_i,
  input  logic signed [SMP_W-1:0] cos_i,
  output logic        [ANG_W-1:0] angle_o,
  output logic                    step_up_o,
  output logic                    step_dn_o,
  output logic signed [ERR_W-1:0] err_o
);

  localparam int EF_W = ERR_W + ERR_FRAC;

  logic        [ANG_W-1:0]  ang_q;
  logic signed [TRIG_W-1:0] sin_phi, cos_phi;
  logic signed [EF_W-1:0]   err_f;
  step_e                    step;

  trk_sincos #(
    .ANG_W (ANG_W),
    .TRIG_W(TRIG_W),
    .LUT_AW(LUT_AW)
  ) u_sincos (
    .ang_i(ang_q),
    .sin_o(sin_phi),
    .cos_o(cos_phi)
  );

  trk_phase_det #(
    .SMP_W   (SMP_W),
    .TRIG_W  (TRIG_W),
    .ANG_W   (ANG_W),
    .EF_W    (EF_W),
    .ERR_FRAC(ERR_FRAC),
    .NOM_AMP (NOM_AMP)
  ) u_pd (
    .sin_i    (sin_i),
    .cos_i    (cos_i),
    .sin_phi_i(sin_phi),
    .cos_phi_i(cos_phi),
    .err_f_o  (err_f)
  );

  trk_loop_filter #(
    .EF_W (EF_W),
    .NCO_F(NCO_F)
  ) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(sample_valid_i),
    .err_f_i(err_f),
    .step_o (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ang_q     <= '0;
      step_up_o <= 1'b0;
      step_dn_o <= 1'b0;
      err_o     <= '0;
    end else begin
      step_up_o <= (step == STEP_UP);
      step_dn_o <= (step == STEP_DN);
      if (step == STEP_UP)      ang_q <= ang_q + 1'b1;
      else if (step == STEP_DN) ang_q <= ang_q - 1'b1;
      if (sample_valid_i) err_o <= ERR_W'(err_f >>> ERR_FRAC);
    end
  end

  assign angle_o = ang_q;

  // R2
  step_up_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_o |-> (angle_o == ANG_W'($past(angle_o) + 1'b1)));

  // R2
  step_dn_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn_o |-> (angle_o == ANG_W'($past(angle_o) - 1'b1)));

  // R2
  move_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(angle_o) |-> $onehot({step_up_o, step_dn_o}));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_valid_i) |-> ($stable(angle_o) && $stable(err_o) && !step_up_o && !step_dn_o));

  // R4
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up_o && ($past(angle_o) == '1)) |-> (angle_o == '0));

endmodule

// File: tb/sim_trk_angle_loop.sv
module sim_trk_angle_loop;

  localparam int  CLK_PER = 10;
  localparam int  WD_CYC  = 190000;
  localparam int  ANG_N   = 16384;
  localparam real AMP     = 16384.0;
  localparam real TWO_PI  = 6.28318530717958647692;
  localparam int  N_VEC   = 8;
  // {input angle, expected settled angle}
  localparam int  VEC [N_VEC][2] = '{
    '{1000, 1000}, '{5000, 5000}, '{9000, 9000}, '{13000, 13000},
    '{16380, 16380}, '{5, 5}, '{16379, 16379}, '{0, 0}};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid = 1'b0;
  logic signed [15:0] sin_s = '0;
  logic signed [15:0] cos_s = 16'sd16384;
  logic [13:0]        angle;
  logic               up, dn;
  logic signed [15:0] err;

  int  n_chk = 0, n_fail = 0;
  int  bad_step = 0, n_up = 0, n_dn = 0;
  bit  saw_wrap_up = 0, saw_wrap_dn = 0;
  int  prev_ang = 0;
  real theta = 0.0;

  trk_angle_loop u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sample_valid_i(valid),
    .sin_i         (sin_s),
    .cos_i         (cos_s),
    .angle_o       (angle),
    .step_up_o     (up),
    .step_dn_o     (dn),
    .err_o         (err)
  );

  always #(CLK_PER / 2) clk = ~clk;

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int wrap_dist(input int a, input int t);
    int d;
    d = (a - t) % ANG_N;
    if (d < 0) d += ANG_N;
    if (d >= ANG_N / 2) d -= ANG_N;
    return d;
  endfunction

  function automatic int tgt(input real th);
    int t;
    t = rnd(th) % ANG_N;
    return (t < 0) ? t + ANG_N : t;
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic set_theta(input real th);
    theta = th;
    sin_s = 16'(rnd(AMP * $sin(TWO_PI * th / real'(ANG_N))));
    cos_s = 16'(rnd(AMP * $cos(TWO_PI * th / real'(ANG_N))));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ramp(input real rate, input int n);
    for (int i = 0; i < n; i++) begin
      set_theta(theta + rate);
      wait_cyc(1);
    end
  endtask

  // port monitor for step shape and wrap crossings
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(angle) != prev_ang) begin
        if (up && !dn && int'(angle) == (prev_ang + 1) % ANG_N) begin
          if (prev_ang == ANG_N - 1) saw_wrap_up = 1;
        end else if (dn && !up && int'(angle) == (prev_ang + ANG_N - 1) % ANG_N) begin
          if (prev_ang == 0) saw_wrap_dn = 1;
        end else bad_step++;
      end else if (up || dn) bad_step++;
      if (up) n_up++;
      if (dn) n_dn++;
    end
    prev_ang = int'(angle);
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a0, e0, up0, dn0;
    // R1 reset state, with a nonzero input present
    set_theta(3000.0);
    valid = 1'b1;
    wait_cyc(5);
    chk(angle == 0, "R1 angle in reset", int'(angle), 0);
    chk(err == 0, "R1 err in reset", int'(err), 0);
    chk(!up && !dn, "R1 strobes in reset", int'({up, dn}), 0);

    // R6 error scaling and sign, single strobes from angle 0
    valid = 1'b0;
    set_theta(20.0);
    rst_n = 1'b1;
    wait_cyc(2);
    valid = 1'b1;
    wait_cyc(1);
    valid = 1'b0;
    wait_cyc(1);
    chk(iabs(int'(err) - 20) <= 1, "R6 err for +20 LSB lead", int'(err), 20);
    chk(angle == 0, "R8 no step on first sample", int'(angle), 0);
    set_theta(-20.0);
    valid = 1'b1;
    wait_cyc(1);
    valid = 1'b0;
    wait_cyc(1);
    chk(iabs(int'(err) + 20) <= 1, "R6 err for -20 LSB lag", int'(err), -20);

    // R3 no sample strobe: nothing moves
    a0 = int'(angle); e0 = int'(err); up0 = n_up; dn0 = n_dn;
    set_theta(300.0);
    wait_cyc(50);
    chk(int'(angle) == a0, "R3 angle held without strobe", int'(angle), a0);
    chk(int'(err) == e0, "R3 err held without strobe", int'(err), e0);
    chk(n_up == up0 && n_dn == dn0, "R3 no strobes without valid", n_up + n_dn, up0 + dn0);

    // R5/R4 lock table, quadrants and wraps
    valid = 1'b1;
    for (int v = 0; v < N_VEC; v++) begin
      set_theta(real'(VEC[v][0]));
      wait_cyc(6000);
      chk(iabs(wrap_dist(int'(angle), VEC[v][1])) <= 1, $sformatf("R5 lock vector %0d", v),
          int'(angle), VEC[v][1]);
      chk(iabs(int'(err)) <= 1, $sformatf("R6 err at lock vector %0d", v), int'(err), 0);
    end
    chk(saw_wrap_up, "R4 wrap 16383->0 on step up", int'(saw_wrap_up), 1);
    chk(saw_wrap_dn, "R4 wrap 0->16383 on step down", int'(saw_wrap_dn), 1);

    // R7 constant-rate tracking
    ramp(0.25, 6000);
    chk(iabs(wrap_dist(int'(angle), tgt(theta))) <= 2, "R7 lag at 0.25 LSB/sample",
        int'(angle), tgt(theta));
    chk(iabs(int'(err)) <= 2, "R7 err at 0.25 LSB/sample", int'(err), 0);
    ramp(0.75, 6000);
    chk(iabs(wrap_dist(int'(angle), tgt(theta))) <= 2, "R7 lag at 0.75 LSB/sample",
        int'(angle), tgt(theta));
    chk(iabs(int'(err)) <= 2, "R7 err at 0.75 LSB/sample", int'(err), 0);
    wait_cyc(3000);
    chk(iabs(wrap_dist(int'(angle), tgt(theta))) <= 1, "R5 lock after ramp",
        int'(angle), tgt(theta));

    // R8 full-rate slew after a large step
    rst_n = 1'b0;
    wait_cyc(2);
    set_theta(6000.0);
    dn0 = n_dn;
    rst_n = 1'b1;
    wait_cyc(3000);
    chk(int'(angle) >= 2975 && int'(angle) <= 3000, "R8 slew one step per sample",
        int'(angle), 3000);
    chk(n_dn == dn0, "R8 slew stays one direction", n_dn - dn0, 0);
    wait_cyc(6000);
    chk(iabs(wrap_dist(int'(angle), 6000)) <= 1, "R5 lock after slew", int'(angle), 6000);

    chk(bad_step == 0, "R2 single-LSB marked steps", bad_step, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule